// File: doc/BRIEF.md
# Multi-CPU Auto-Masking Interrupt Controller

This block collects a set of level-sensitive hardware interrupt lines and steers each one to any subset of the CPUs in a cluster. Every line has one mask bit, one software-trigger bit and one CPU affinity vector. The software-trigger bit is ORed with the hardware level, so software can raise or hold a line with no hardware source. In addition, each CPU owns two inter-processor interrupts (IPIs). Any CPU can raise either of them on any group of CPUs, and the two behave the same way.

A CPU services interrupts by reading its single event register. The read returns the most urgent source that is pending for that CPU and, in the same access, masks that source. A handler therefore has to unmask a source before the source can be delivered again. Each CPU has one interrupt output, driven combinationally from the current state and the hardware levels.

Register access uses a simple single-cycle bus. An access is accepted in every cycle in which `bus_req` is high, with no back-pressure. Read data is returned one cycle later, qualified by `bus_rvalid`. The caller names itself on `bus_cpu`. Window 0 of the per-CPU area acts on that caller. Windows 1 to N act on CPU 0 to N-1, whoever issues the access.

Top module: `irq_fanout_ctrl`

## Requirements
- R1: After reset, `irq_out` is 0. All line mask bits read as 1, all software-trigger bits as 0 and every affinity vector as 0. Both IPIs of every CPU are masked and none is pending, so the IPI status word reads 0x300.
- R2: The effective request of line n is `hw_irq[n] | sw[n]`. `irq_out[c]` is high in the same cycle whenever CPU c has an unmasked effective request whose affinity bit c is set, or an IPI that is both pending and unmasked.
- R3: Line-group registers at 0x40+k. Writing 1 to a bit sets it and writing 0 leaves it unchanged, for these offsets: k=0 sets mask bits, k=1 clears mask bits, k=2 sets software-trigger bits, k=3 clears software-trigger bits. Reads at k=4, 5 and 6 return the mask, the software-trigger bits and the raw hardware levels. Reading a line-group offset other than 4, 5 or 6 returns 0.
- R4: The affinity of line n is at word 0x80+n. Bits [NCPU-1:0] of this word select the CPUs that may receive line n, and the word reads back the stored value.
- R5: A read returns its data on `bus_rdata` with `bus_rvalid` high in the cycle after the access. The event word carries a kind in bits [17:16] (0 none, 1 hardware line, 2 IPI) and the line or IPI number in the low bits. When nothing is pending the whole word is 0.
- R6: In the event register, IPI 0 outranks IPI 1, and IPI 1 outranks every hardware line. Among hardware lines, the lowest-numbered eligible line wins.
- R7: When an event read returns a hardware line, that line's mask bit is set in the same access. If no other source is left for the CPU, its `irq_out` bit falls in the cycle after the read.
- R8: A write to per-CPU offset 1 raises IPIs. For each CPU c, bit c raises IPI 0 on CPU c and bit 8+c raises IPI 1 on CPU c. Any CPU may issue this write.
- R9: An event read that returns an IPI clears its pending bit and sets its mask bit. A masked IPI stays undelivered, and a new raise keeps it pending. Per-CPU offset 2 sets IPI mask bits [1:0] and offset 3 clears them. Offset 4 reads the status word, with mask in [9:8] and pending in [1:0].
- R10: The per-CPU word address is {2'b00, window[2:0], offset[2:0]}. Window 0 addresses CPU `bus_cpu`, and window w (1..NCPU) addresses CPU w-1.
- R11: Writes to the event offset are ignored. Reads of the write-only offsets 1, 2 and 3 return 0. Accesses to a window above NCPU have no effect and read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hw_irq | input | NLINES | Level-sensitive hardware interrupt lines |
| bus_req | input | 1 | Access request; accepted every cycle it is high |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | AW | Word address |
| bus_cpu | input | CW | Index of the CPU issuing the access |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | High the cycle after a read access |
| irq_out | output | NCPU | Interrupt request to each CPU |

## Verification
The interrupt outputs are combinational. The bench therefore compares `irq_out` with its model shortly after each hardware-level change, and again at the falling edge after every bus access, once the register update at the rising edge has taken effect. Read data and `bus_rvalid` are due one rising edge after the access. The bench drives each access on a falling edge and samples at the next falling edge, and it applies the acknowledge side effects to its model only after taking the expected value from the pre-access state. As a result, the drop of an output after a masking read shows up in the very check that follows that read.

// File: rtl/ifc_pkg.sv
package ifc_pkg;
  typedef enum logic [1:0] {
    EV_NONE = 2'd0,
    EV_LINE = 2'd1,
    EV_IPI  = 2'd2
  } ev_kind_e;

  // address regions (word address bits [7:6])
  localparam logic [1:0] RG_CPU  = 2'd0;
  localparam logic [1:0] RG_LINE = 2'd1;
  localparam logic [1:0] RG_AFF  = 2'd2;

  // per-CPU window offsets
  localparam logic [2:0] PC_EVENT = 3'd0;
  localparam logic [2:0] PC_SEND  = 3'd1;
  localparam logic [2:0] PC_MSET  = 3'd2;
  localparam logic [2:0] PC_MCLR  = 3'd3;
  localparam logic [2:0] PC_STAT  = 3'd4;

  // line-group offsets
  localparam logic [2:0] LG_MSET = 3'd0;
  localparam logic [2:0] LG_MCLR = 3'd1;
  localparam logic [2:0] LG_SSET = 3'd2;
  localparam logic [2:0] LG_SCLR = 3'd3;
  localparam logic [2:0] LG_MASK = 3'd4;
  localparam logic [2:0] LG_SW   = 3'd5;
  localparam logic [2:0] LG_HW   = 3'd6;

  localparam int KIND_LSB = 16;
endpackage

// File: rtl/ifc_prio_pick.sv
module ifc_prio_pick #(
  parameter int N = 32,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req,
  output logic          found,
  output logic [IW-1:0] idx
);
  logic [N-1:0] lowest;

  // isolate the lowest set bit: it is the winner
  assign lowest = req & (~req + N'(1));
  assign found  = |req;

  always_comb begin
    idx = '0;
    for (int i = 0; i < N; i++) begin
      if (lowest[i]) idx = idx | IW'(i);
    end
  end
endmodule

// File: rtl/ifc_line_regs.sv
module ifc_line_regs #(
  parameter int NLINES = 32,
  parameter int NCPU   = 4,
  parameter int DW     = 32,
  localparam int LW    = (NLINES > 1) ? $clog2(NLINES) : 1
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_mset,
  input  logic                          wr_mclr,
  input  logic                          wr_sset,
  input  logic                          wr_sclr,
  input  logic                          wr_aff,
  input  logic [LW-1:0]                 aff_idx,
  input  logic [DW-1:0]                 wdata,
  input  logic [NLINES-1:0]             ack_mask,
  output logic [NLINES-1:0]             mask_q,
  output logic [NLINES-1:0]             sw_q,
  output logic [NLINES-1:0][NCPU-1:0]   aff_row,
  output logic [NCPU-1:0][NLINES-1:0]   aff_col
);
  logic [NLINES-1:0] wbits;
  assign wbits = wdata[NLINES-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '1;
      sw_q   <= '0;
    end else begin
      mask_q <= (mask_q | (wr_mset ? wbits : '0) | ack_mask)
                & ~(wr_mclr ? wbits : '0);
      sw_q   <= (sw_q | (wr_sset ? wbits : '0)) & ~(wr_sclr ? wbits : '0);
    end
  end

  for (genvar n = 0; n < NLINES; n++) begin : g_line
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        aff_row[n] <= '0;
      else if (wr_aff && aff_idx == LW'(n))
        aff_row[n] <= wdata[NCPU-1:0];
    end
    for (genvar c = 0; c < NCPU; c++) begin : g_cpu
      assign aff_col[c][n] = aff_row[n][c];
    end
  end
endmodule

// File: rtl/ifc_cpu_port.sv
module ifc_cpu_port
  import ifc_pkg::*;
#(
  parameter int NLINES = 32,
  parameter int DW     = 32,
  localparam int LW    = (NLINES > 1) ? $clog2(NLINES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NLINES-1:0] line_req,
  input  logic [NLINES-1:0] aff_col,
  input  logic [1:0]        ipi_raise,
  input  logic [1:0]        ipi_mset,
  input  logic [1:0]        ipi_mclr,
  input  logic              ack,
  output logic              irq,
  output logic [DW-1:0]     ev_word,
  output logic [NLINES-1:0] ack_line,
  output logic [1:0]        ipi_pend,
  output logic [1:0]        ipi_mask
);
  logic [NLINES-1:0] elig;
  logic [1:0]        ipi_live;
  logic              line_found;
  logic [LW-1:0]     line_idx;
  ev_kind_e          kind;
  logic [1:0]        ipi_take;

  assign elig     = line_req & aff_col;
  assign ipi_live = ipi_pend & ~ipi_mask;

  ifc_prio_pick #(.N(NLINES)) u_pick (
    .req   (elig),
    .found (line_found),
    .idx   (line_idx)
  );

  always_comb begin
    ev_word  = '0;
    ipi_take = 2'b00;
    kind     = EV_NONE;
    if (ipi_live[0]) begin
      kind        = EV_IPI;
      ipi_take[0] = 1'b1;
    end else if (ipi_live[1]) begin
      kind        = EV_IPI;
      ipi_take[1] = 1'b1;
      ev_word[0]  = 1'b1;
    end else if (line_found) begin
      kind             = EV_LINE;
      ev_word[LW-1:0]  = line_idx;
    end
    ev_word[KIND_LSB+1:KIND_LSB] = kind;
  end

  always_comb begin
    ack_line = '0;
    if (ack && kind == EV_LINE) ack_line[line_idx] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ipi_pend <= 2'b00;
      ipi_mask <= 2'b11;
    end else begin
      ipi_pend <= (ipi_pend & ~(ack ? ipi_take : 2'b00)) | ipi_raise;
      ipi_mask <= (ipi_mask | ipi_mset | (ack ? ipi_take : 2'b00)) & ~ipi_mclr;
    end
  end

  assign irq = (|ipi_live) | line_found;
endmodule

// File: rtl/irq_fanout_ctrl.sv
module irq_fanout_ctrl
  import ifc_pkg::*;
#(
  parameter int NLINES = 32,
  parameter int NCPU   = 4,
  parameter int AW     = 8,
  parameter int DW     = 32,
  localparam int CW    = (NCPU > 1) ? $clog2(NCPU) : 1,
  localparam int LW    = (NLINES > 1) ? $clog2(NLINES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NLINES-1:0] hw_irq,
  input  logic              bus_req,
  input  logic              bus_we,
  input  logic [AW-1:0]     bus_addr,
  input  logic [CW-1:0]     bus_cpu,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  output logic              bus_rvalid,
  output logic [NCPU-1:0]   irq_out
);
  logic [1:0] region;
  logic [2:0] win, off, tgt;
  logic       win_ok, acc_rd, acc_wr, in_cpu, in_line, aff_hit;

  logic [NLINES-1:0]             line_mask, line_sw, line_req, ack_any;
  logic [NLINES-1:0][NCPU-1:0]   aff_row;
  logic [NCPU-1:0][NLINES-1:0]   aff_col, ack_line;
  logic [NCPU-1:0][DW-1:0]       ev_word;
  logic [NCPU-1:0][1:0]          ipi_pend, ipi_mask_all;
  logic [DW-1:0]                 rd_mux;

  assign region  = bus_addr[7:6];
  assign win     = bus_addr[5:3];
  assign off     = bus_addr[2:0];
  assign acc_rd  = bus_req & ~bus_we;
  assign acc_wr  = bus_req & bus_we;

  always_comb begin
    if (win == 3'd0) begin
      tgt    = 3'(bus_cpu);
      win_ok = (int'(bus_cpu) < NCPU);
    end else begin
      tgt    = win - 3'd1;
      win_ok = (int'(win) <= NCPU);
    end
  end

  assign in_cpu  = (region == RG_CPU) && win_ok;
  assign in_line = (region == RG_LINE);
  assign aff_hit = (region == RG_AFF) && (int'(bus_addr[5:0]) < NLINES);

  always_comb begin
    ack_any = '0;
    for (int c = 0; c < NCPU; c++) ack_any = ack_any | ack_line[c];
  end

  ifc_line_regs #(.NLINES(NLINES), .NCPU(NCPU), .DW(DW)) u_lines (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_mset  (acc_wr && in_line && off == LG_MSET),
    .wr_mclr  (acc_wr && in_line && off == LG_MCLR),
    .wr_sset  (acc_wr && in_line && off == LG_SSET),
    .wr_sclr  (acc_wr && in_line && off == LG_SCLR),
    .wr_aff   (acc_wr && aff_hit),
    .aff_idx  (bus_addr[LW-1:0]),
    .wdata    (bus_wdata),
    .ack_mask (ack_any),
    .mask_q   (line_mask),
    .sw_q     (line_sw),
    .aff_row  (aff_row),
    .aff_col  (aff_col)
  );

  assign line_req = (hw_irq | line_sw) & ~line_mask;

  for (genvar c = 0; c < NCPU; c++) begin : g_cpu
    logic sel;
    assign sel = in_cpu && (tgt == 3'(c));

    ifc_cpu_port #(.NLINES(NLINES), .DW(DW)) u_port (
      .clk       (clk),
      .rst_n     (rst_n),
      .line_req  (line_req),
      .aff_col   (aff_col[c]),
      .ipi_raise ((acc_wr && in_cpu && off == PC_SEND) ?
                  {bus_wdata[8+c], bus_wdata[c]} : 2'b00),
      .ipi_mset  ((acc_wr && sel && off == PC_MSET) ? bus_wdata[1:0] : 2'b00),
      .ipi_mclr  ((acc_wr && sel && off == PC_MCLR) ? bus_wdata[1:0] : 2'b00),
      .ack       (acc_rd && sel && off == PC_EVENT),
      .irq       (irq_out[c]),
      .ev_word   (ev_word[c]),
      .ack_line  (ack_line[c]),
      .ipi_pend  (ipi_pend[c]),
      .ipi_mask  (ipi_mask_all[c])
    );
  end

  always_comb begin
    rd_mux = '0;
    if (in_cpu) begin
      for (int c = 0; c < NCPU; c++) begin
        if (tgt == 3'(c)) begin
          if (off == PC_EVENT) rd_mux = ev_word[c];
          if (off == PC_STAT) begin
            rd_mux[1:0] = ipi_pend[c];
            rd_mux[9:8] = ipi_mask_all[c];
          end
        end
      end
    end else if (in_line) begin
      case (off)
        LG_MASK: rd_mux[NLINES-1:0] = line_mask;
        LG_SW:   rd_mux[NLINES-1:0] = line_sw;
        LG_HW:   rd_mux[NLINES-1:0] = hw_irq;
        default: rd_mux = '0;
      endcase
    end else if (aff_hit) begin
      rd_mux[NCPU-1:0] = aff_row[bus_addr[LW-1:0]];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rvalid <= 1'b0;
      bus_rdata  <= '0;
    end else begin
      bus_rvalid <= acc_rd;
      if (acc_rd) bus_rdata <= rd_mux;
    end
  end
endmodule

// File: rtl/irq_fanout_ctrl_chk.sv
module irq_fanout_ctrl_chk #(
  parameter int NLINES = 32,
  parameter int NCPU   = 4,
  parameter int AW     = 8,
  parameter int DW     = 32,
  localparam int CW    = (NCPU > 1) ? $clog2(NCPU) : 1,
  localparam int LW    = (NLINES > 1) ? $clog2(NLINES) : 1
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 bus_req,
  input logic                 bus_we,
  input logic [AW-1:0]        bus_addr,
  input logic [CW-1:0]        bus_cpu,
  input logic [DW-1:0]        bus_rdata,
  input logic                 bus_rvalid,
  input logic [NCPU-1:0]      irq_out,
  input logic [NLINES-1:0]    line_mask,
  input logic [NCPU-1:0][1:0] ipi_mask_all
);
  logic       ev_rd_q;
  logic [2:0] tgt_q;
  logic [2:0] w_tgt;
  logic       w_ok;

  always_comb begin
    if (bus_addr[5:3] == 3'd0) begin
      w_tgt = 3'(bus_cpu);
      w_ok  = (int'(bus_cpu) < NCPU);
    end else begin
      w_tgt = bus_addr[5:3] - 3'd1;
      w_ok  = (int'(bus_addr[5:3]) <= NCPU);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ev_rd_q <= 1'b0;
      tgt_q   <= '0;
    end else begin
      ev_rd_q <= bus_req && !bus_we && bus_addr[7:6] == 2'd0 &&
                 bus_addr[2:0] == 3'd0 && w_ok;
      tgt_q   <= w_tgt;
    end
  end

  p_rvalid_after_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rvalid |-> $past(bus_req && !bus_we));

  p_kind_legal_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ev_rd_q |-> bus_rdata[17:16] != 2'b11);

  p_none_is_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_rd_q && bus_rdata[17:16] == 2'd0) |-> bus_rdata == '0);

  p_line_ack_masks_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_rd_q && bus_rdata[17:16] == 2'd1) |-> line_mask[bus_rdata[LW-1:0]]);

  p_ipi_ack_masks_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_rd_q && bus_rdata[17:16] == 2'd2) |-> ipi_mask_all[tgt_q][bus_rdata[0]]);

  p_all_masked_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ((&line_mask) && (&ipi_mask_all)) |-> irq_out == '0);
endmodule

bind irq_fanout_ctrl irq_fanout_ctrl_chk #(
  .NLINES(NLINES), .NCPU(NCPU), .AW(AW), .DW(DW)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .bus_req      (bus_req),
  .bus_we       (bus_we),
  .bus_addr     (bus_addr),
  .bus_cpu      (bus_cpu),
  .bus_rdata    (bus_rdata),
  .bus_rvalid   (bus_rvalid),
  .irq_out      (irq_out),
  .line_mask    (line_mask),
  .ipi_mask_all (ipi_mask_all)
);

// File: tb/irq_fanout_ctrl_test.sv
module irq_fanout_ctrl_test;
  localparam int NL = 32;
  localparam int NC = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NL-1:0] hw_irq = '0;
  logic          bus_req = 1'b0, bus_we = 1'b0;
  logic [7:0]    bus_addr = '0;
  logic [1:0]    bus_cpu = '0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic          bus_rvalid;
  logic [NC-1:0] irq_out;

  always #10 clk = ~clk;

  irq_fanout_ctrl #(.NLINES(NL), .NCPU(NC), .AW(8), .DW(32)) uut (
    .clk(clk), .rst_n(rst_n), .hw_irq(hw_irq), .bus_req(bus_req),
    .bus_we(bus_we), .bus_addr(bus_addr), .bus_cpu(bus_cpu),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
    .irq_out(irq_out));

  int vec_cnt = 0;
  int bad_cnt = 0;

  // reference model
  logic [NL-1:0] m_mask, m_sw;
  logic [NC-1:0] m_aff [NL];
  logic [1:0]    m_ipend [NC];
  logic [1:0]    m_imask [NC];

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    vec_cnt++;
    if (act !== exp) begin
      bad_cnt++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] m_event(int c);
    logic [1:0] live = m_ipend[c] & ~m_imask[c];
    if (live[0]) return 32'h0002_0000;
    if (live[1]) return 32'h0002_0001;
    for (int n = 0; n < NL; n++)
      if ((hw_irq[n] | m_sw[n]) && !m_mask[n] && m_aff[n][c])
        return 32'h0001_0000 | n;
    return 32'h0;
  endfunction

  function automatic logic [31:0] m_irq();
    logic [31:0] v = '0;
    for (int c = 0; c < NC; c++) v[c] = (m_event(c) != 0);
    return v;
  endfunction

  function automatic int m_tgt(logic [7:0] a, int cpu);
    if (a[5:3] == 3'd0) return cpu;
    return int'(a[5:3]) - 1;
  endfunction

  task automatic m_write(logic [7:0] a, logic [31:0] d, int cpu);
    int t = m_tgt(a, cpu);
    if (a[7:6] == 2'd0 && t < NC) begin
      case (a[2:0])
        3'd1: for (int c = 0; c < NC; c++) begin
                if (d[c])   m_ipend[c][0] = 1'b1;
                if (d[8+c]) m_ipend[c][1] = 1'b1;
              end
        3'd2: m_imask[t] = m_imask[t] | d[1:0];
        3'd3: m_imask[t] = m_imask[t] & ~d[1:0];
        default: ;
      endcase
    end else if (a[7:6] == 2'd1) begin
      case (a[2:0])
        3'd0: m_mask = m_mask | d;
        3'd1: m_mask = m_mask & ~d;
        3'd2: m_sw = m_sw | d;
        3'd3: m_sw = m_sw & ~d;
        default: ;
      endcase
    end else if (a[7:6] == 2'd2 && a[5:0] < NL) begin
      m_aff[a[5:0]] = d[NC-1:0];
    end
  endtask

  task automatic m_read(logic [7:0] a, int cpu, output logic [31:0] v);
    int t = m_tgt(a, cpu);
    v = '0;
    if (a[7:6] == 2'd0 && t < NC) begin
      if (a[2:0] == 3'd0) begin
        v = m_event(t);
        if (v[17:16] == 2'd2) begin
          m_ipend[t][v[0]] = 1'b0;
          m_imask[t][v[0]] = 1'b1;
        end else if (v[17:16] == 2'd1) begin
          m_mask[v[4:0]] = 1'b1;
        end
      end else if (a[2:0] == 3'd4) begin
        v = {22'd0, m_imask[t], 6'd0, m_ipend[t]};
      end
    end else if (a[7:6] == 2'd1) begin
      case (a[2:0])
        3'd4: v = m_mask;
        3'd5: v = m_sw;
        3'd6: v = hw_irq;
        default: v = '0;
      endcase
    end else if (a[7:6] == 2'd2 && a[5:0] < NL) begin
      v = 32'(m_aff[a[5:0]]);
    end
  endtask

  task automatic do_wr(logic [7:0] a, logic [31:0] d, int cpu);
    @(negedge clk);
    bus_req = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    bus_cpu = 2'(cpu);
    @(negedge clk);
    bus_req = 1'b0; bus_we = 1'b0;
    m_write(a, d, cpu);
    chk("R2 irq after write", 32'(irq_out), m_irq());
  endtask

  task automatic do_rd(logic [7:0] a, int cpu, string tag,
                       output logic [31:0] act);
    logic [31:0] exp;
    @(negedge clk);
    bus_req = 1'b1; bus_we = 1'b0; bus_addr = a; bus_cpu = 2'(cpu);
    m_read(a, cpu, exp);
    @(negedge clk);
    bus_req = 1'b0;
    act = bus_rdata;
    chk("R5 rvalid", 32'(bus_rvalid), 32'd1);
    chk(tag, act, exp);
    chk("R7 irq after read", 32'(irq_out), m_irq());
  endtask

  task automatic set_hw(logic [NL-1:0] v);
    @(negedge clk);
    hw_irq = v;
    #1;
    chk("R2 irq on level", 32'(irq_out), m_irq());
  endtask

  function automatic logic [7:0] wa(int w, int o);
    return 8'((w << 3) | o);
  endfunction

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, bad_cnt);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad_cnt++;
    $display("FAIL watchdog: actual hung expected done");
    summary();
  end

  initial begin
    logic [31:0] r;
    void'($urandom(32'd20240611));
    m_mask = '1; m_sw = '0;
    for (int n = 0; n < NL; n++) m_aff[n] = '0;
    for (int c = 0; c < NC; c++) begin m_ipend[c] = 2'b00; m_imask[c] = 2'b11; end

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 irq idle", 32'(irq_out), 32'h0);
    chk("R1 rvalid idle", 32'(bus_rvalid), 32'h0);
    do_rd(8'h44, 0, "R1 mask reset", r);   chk("R1 mask all set", r, 32'hFFFF_FFFF);
    do_rd(8'h45, 0, "R1 sw reset", r);     chk("R1 sw clear", r, 32'h0);
    do_rd(8'h80, 0, "R1 aff reset", r);    chk("R1 aff zero", r, 32'h0);
    do_rd(wa(3, 4), 0, "R1 ipi stat", r);  chk("R1 ipi masked", r, 32'h300);

    // priority among lines and masking on ack
    do_wr(8'h83, 32'h1, 0);
    do_wr(8'h85, 32'h1, 0);
    do_rd(8'h85, 0, "R4 aff readback", r); chk("R4 aff value", r, 32'h1);
    do_wr(8'h41, 32'h28, 0);
    set_hw(32'h28);
    chk("R2 line level raises cpu0", 32'(irq_out), 32'h1);
    do_rd(wa(1, 0), 2, "R6 lowest line", r); chk("R6 line 3 first", r, 32'h0001_0003);
    chk("R7 irq held by line 5", 32'(irq_out), 32'h1);
    do_rd(wa(1, 0), 2, "R7 next line", r);   chk("R7 line 5", r, 32'h0001_0005);
    chk("R7 irq dropped", 32'(irq_out), 32'h0);
    do_rd(wa(1, 0), 2, "R5 empty", r);       chk("R5 none is zero", r, 32'h0);
    do_rd(8'h44, 0, "R7 mask view", r);     chk("R7 masks set", r, 32'hFFFF_FFFF);

    // software trigger, affinity to cpu1, default window
    set_hw(32'h0);
    do_wr(8'h87, 32'h2, 0);
    do_wr(8'h41, 32'h80, 0);
    do_wr(8'h42, 32'h80, 0);
    chk("R2 sw ored", 32'(irq_out), 32'h2);
    do_rd(wa(0, 0), 1, "R10 default window", r); chk("R10 own event", r, 32'h0001_0007);
    do_rd(8'h45, 0, "R3 sw kept", r);       chk("R3 sw bit 7", r, 32'h80);

    // IPIs: masked at reset, priority over lines
    do_wr(wa(0, 1), 32'h0202, 2);
    chk("R9 masked ipi silent", 32'(irq_out), 32'h0);
    do_rd(wa(2, 4), 3, "R8 ipi raised", r); chk("R8 both pending", r, 32'h303);
    do_wr(wa(2, 3), 32'h3, 0);
    do_wr(8'h41, 32'h80, 0);
    do_rd(wa(2, 0), 0, "R6 ipi0 first", r);  chk("R6 ipi0", r, 32'h0002_0000);
    do_rd(wa(2, 0), 0, "R6 ipi1 next", r);   chk("R6 ipi1", r, 32'h0002_0001);
    do_rd(wa(2, 0), 0, "R6 line last", r);   chk("R6 line 7", r, 32'h0001_0007);
    do_wr(wa(0, 1), 32'h0002, 3);
    chk("R9 re-raise masked", 32'(irq_out), 32'h0);
    do_rd(wa(2, 4), 0, "R9 stat", r);        chk("R9 pend masked", r, 32'h301);

    // ignored accesses
    do_wr(wa(2, 0), 32'hFFFF_FFFF, 1);
    do_rd(wa(2, 4), 0, "R11 event write ignored", r); chk("R11 stat same", r, 32'h301);
    do_rd(wa(2, 1), 0, "R11 send reads zero", r);     chk("R11 zero", r, 32'h0);
    do_wr(wa(7, 3), 32'h3, 0);
    do_rd(wa(2, 4), 0, "R11 bad window", r);          chk("R11 stat kept", r, 32'h301);
    do_rd(wa(7, 4), 0, "R11 bad window read", r);     chk("R11 bad read zero", r, 32'h0);

    // constrained random traffic
    for (int i = 0; i < 4000; i++) begin
      int op = $urandom_range(0, 11);
      int w = $urandom_range(0, NC);
      int cpu = $urandom_range(0, NC - 1);
      if ($urandom_range(0, 7) == 0) set_hw($urandom & $urandom);
      case (op)
        0: do_wr(8'h40, $urandom & $urandom & $urandom, cpu);
        1: do_wr(8'h41, $urandom, cpu);
        2: do_wr(8'h42, $urandom & $urandom & $urandom, cpu);
        3: do_wr(8'h43, $urandom, cpu);
        4: do_wr(8'(8'h80 + $urandom_range(0, NL - 1)), $urandom, cpu);
        5: do_wr(wa(w, 1), $urandom & 32'h0F0F & $urandom, cpu);
        6: do_wr(wa(w, $urandom_range(2, 3)), $urandom, cpu);
        7: do_rd(wa(w, 4), cpu, "R9 random stat", r);
        8: do_rd(8'(8'h44 + $urandom_range(0, 3)), cpu, "R3 random line read", r);
        9: do_rd(8'(8'h80 + $urandom_range(0, NL - 1)), cpu, "R4 random aff", r);
        default: do_rd(wa(w, 0), cpu, "R6 random event", r);
      endcase
    end
    summary();
  end
endmodule